// File: doc/BRIEF.md
# Predicated Lane-Chained Add/Subtract-With-Carry Unit

This block adds or subtracts two 128-bit vectors as four 32-bit lanes. The carry out of one lane feeds the carry into the next lane, so the whole vector behaves as one wide operation that can be chained across instructions through a carry flag. Subtraction adds the bitwise inverse of the second operand, and the initial carry supplies the "+1".

A 16-bit predicate gives one bit per byte. The lowest predicate bit of each lane decides whether that lane takes part in the carry chain. Each predicate bit decides whether its destination byte is written with the new result or keeps the byte of the old destination vector. A four-bit flag word comes in and an updated one goes out. The initial carry comes either from the incoming C flag or from a fixed immediate. The immediate is ignored when the first beat of the operation was skipped.

A one-cycle `start` strobe captures the inputs. The merged vector and the new flags appear on the next clock edge, together with a one-cycle `valid` pulse, and are held until the next start.

Top module: `vac_unit`

## Requirements
- R1: Lanes are bits [32i+31:32i] for i = 0..3 and are chained from lane 0 upward. Each lane forms the 33-bit sum of its first operand, its second operand and its carry-in, and bit 32 of that sum is the lane's carry-out. The final carry is the carry leaving lane 3.
- R2: When `op_sub` is 1, the lane's second operand is replaced by its bitwise inverse before the addition. Nothing else changes.
- R3: Lane i is active when `pred[4i]` is 1. An active lane's carry-out becomes the running carry. An inactive lane passes its carry-in on unchanged, although its sum is still formed with that carry-in.
- R4: Output byte k (bits [8k+7:8k]) takes the result byte when `pred[k]` is 1 and the byte of `dst_old` otherwise. This holds for every one of the 16 bits, not only the lane-enable bits.
- R5: When no lane is active, `flags_out` equals the effective incoming flags. These are `flags_in`, or {N=0, Z=0, C=fixed, V=0} when the immediate case of R8 applies.
- R6: Flag bit order is N=bit 3, Z=bit 2, C=bit 1, V=bit 0. When at least one lane is active, `flags_out` has C equal to the final carry and N, Z and V equal to 0.
- R7: When `imm_carry` is 0, the initial carry into lane 0 is `flags_in[1]`.
- R8: When `imm_carry` is 1 and `skip_first` is 0, the initial carry is 0 for add and 1 for subtract, and the incoming N, Z and V are taken as 0.
- R9: When `imm_carry` is 1 and `skip_first` is 1, the block behaves exactly as if `imm_carry` were 0.
- R10: `valid` is 1 exactly in the cycle after a `start` cycle. `dst_out` and `flags_out` update only on a start and hold otherwise. Synchronous active-high `rst` clears `valid`, `dst_out` and `flags_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture inputs and compute |
| op_sub | input | 1 | 0 = add with carry, 1 = subtract with carry |
| imm_carry | input | 1 | Use fixed initial carry instead of C flag |
| skip_first | input | 1 | First beat was skipped; overrides the fixed carry |
| src_a | input | 128 | First operand vector |
| src_b | input | 128 | Second operand vector |
| dst_old | input | 128 | Previous destination vector |
| pred | input | 16 | Per-byte predicate |
| flags_in | input | 4 | Incoming N,Z,C,V |
| dst_out | output | 128 | Merged destination vector |
| flags_out | output | 4 | Updated N,Z,C,V |
| valid | output | 1 | One-cycle result strobe |

## Verification
Operands of all ones plus one in lane 0 show whether the carry ripples through every lane. A predicate that leaves lane 1 inactive while its sum would overflow shows whether an inactive lane wrongly passes on its own carry. Irregular byte predicates whose lane-enable bits are clear separate the byte-merge rule from the carry rule, and at the same time check that the flags are left alone. The four combinations of immediate flag, skipped first beat, and add or subtract, each with an incoming C that differs from the fixed value, show which initial carry was chosen. Random operations then cover mixed patterns against the behavioural model.

// File: rtl/vac_pkg.sv
package vac_pkg;
    localparam int LANE_W     = 32;
    localparam int LANES      = 4;
    localparam int BYTE_W     = 8;
    localparam int LANE_BYTES = LANE_W / BYTE_W;
    localparam int VEC_W      = LANE_W * LANES;
    localparam int PRED_W     = VEC_W / BYTE_W;
    localparam int FLAG_W     = 4;
    localparam int FLG_N      = 3;
    localparam int FLG_Z      = 2;
    localparam int FLG_C      = 1;
    localparam int FLG_V      = 0;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    typedef struct packed {
        logic [VEC_W-1:0]  data;
        logic [FLAG_W-1:0] flags;
    } result_t;

    // Flag word carrying only a carry, other flags cleared
    function automatic logic [FLAG_W-1:0] carry_only_flags(input logic c);
        logic [FLAG_W-1:0] f;
        f        = '0;
        f[FLG_C] = c;
        return f;
    endfunction
endpackage

// File: rtl/vac_lane.sv
module vac_lane
    import vac_pkg::*;
#(
    parameter int W = LANE_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  op_e          op,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    always_comb begin
        b_eff = (op == OP_SUB) ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
        sum   = wide[W-1:0];
        cout  = wide[W];
    end
endmodule

// File: rtl/vac_chain.sv
module vac_chain
    import vac_pkg::*;
#(
    parameter int LW = LANE_W,
    parameter int NL = LANES,
    localparam int VW = LW * NL
) (
    input  logic [VW-1:0] a,
    input  logic [VW-1:0] b,
    input  op_e           op,
    input  logic          cin0,
    input  logic [NL-1:0] act,
    output logic [VW-1:0] res,
    output logic          cfinal
);
    logic [NL:0] carry;

    assign carry[0] = cin0;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic co;
        vac_lane #(.W(LW)) u_lane (
            .a   (a[i*LW +: LW]),
            .b   (b[i*LW +: LW]),
            .op  (op),
            .cin (carry[i]),
            .sum (res[i*LW +: LW]),
            .cout(co)
        );
        assign carry[i+1] = act[i] ? co : carry[i];
    end

    assign cfinal = carry[NL];
endmodule

// File: rtl/vac_merge.sv
module vac_merge
    import vac_pkg::*;
#(
    parameter int VW = VEC_W,
    parameter int BW = BYTE_W,
    localparam int NB = VW / BW
) (
    input  logic [VW-1:0] fresh,
    input  logic [VW-1:0] old,
    input  logic [NB-1:0] mask,
    output logic [VW-1:0] merged
);
    for (genvar k = 0; k < NB; k++) begin : g_byte
        assign merged[k*BW +: BW] = mask[k] ? fresh[k*BW +: BW] : old[k*BW +: BW];
    end
endmodule

// File: rtl/vac_flags.sv
module vac_flags
    import vac_pkg::*;
(
    input  logic [FLAG_W-1:0] flags_in,
    input  op_e               op,
    input  logic              imm_carry,
    input  logic              skip_first,
    input  logic              any_act,
    input  logic              cfinal,
    output logic              cin0,
    output logic [FLAG_W-1:0] flags_next
);
    logic [FLAG_W-1:0] eff;

    always_comb begin
        if (imm_carry && !skip_first)
            eff = carry_only_flags(op == OP_SUB);
        else
            eff = flags_in;
        cin0       = eff[FLG_C];
        flags_next = any_act ? carry_only_flags(cfinal) : eff;
    end
endmodule

// File: rtl/vac_unit.sv
module vac_unit
    import vac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              op_sub,
    input  logic              imm_carry,
    input  logic              skip_first,
    input  logic [VEC_W-1:0]  src_a,
    input  logic [VEC_W-1:0]  src_b,
    input  logic [VEC_W-1:0]  dst_old,
    input  logic [PRED_W-1:0] pred,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [VEC_W-1:0]  dst_out,
    output logic [FLAG_W-1:0] flags_out,
    output logic              valid
);
    op_e              op;
    logic [LANES-1:0] act;
    logic             cin0;
    logic             cfinal;
    logic [VEC_W-1:0] raw;
    result_t          nxt;
    result_t          cur;
    logic             vld_q;

    assign op = op_sub ? OP_SUB : OP_ADD;

    for (genvar i = 0; i < LANES; i++) begin : g_act
        assign act[i] = pred[i*LANE_BYTES];
    end

    vac_flags u_flags (
        .flags_in  (flags_in),
        .op        (op),
        .imm_carry (imm_carry),
        .skip_first(skip_first),
        .any_act   (|act),
        .cfinal    (cfinal),
        .cin0      (cin0),
        .flags_next(nxt.flags)
    );

    vac_chain #(.LW(LANE_W), .NL(LANES)) u_chain (
        .a     (src_a),
        .b     (src_b),
        .op    (op),
        .cin0  (cin0),
        .act   (act),
        .res   (raw),
        .cfinal(cfinal)
    );

    vac_merge #(.VW(VEC_W), .BW(BYTE_W)) u_merge (
        .fresh (raw),
        .old   (dst_old),
        .mask  (pred),
        .merged(nxt.data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur   <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= start;
            if (start) cur <= nxt;
        end
    end

    assign dst_out   = cur.data;
    assign flags_out = cur.flags;
    assign valid     = vld_q;
endmodule

// File: rtl/vac_unit_chk.sv
module vac_unit_chk
    import vac_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              imm_carry,
    input logic              skip_first,
    input logic [VEC_W-1:0]  dst_old,
    input logic [PRED_W-1:0] pred,
    input logic [FLAG_W-1:0] flags_in,
    input logic [VEC_W-1:0]  dst_out,
    input logic [FLAG_W-1:0] flags_out,
    input logic              valid
);
    logic any_lane;
    always_comb begin
        any_lane = 1'b0;
        for (int i = 0; i < LANES; i++) any_lane = any_lane | pred[i*LANE_BYTES];
    end

    AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        start |=> valid);                                                   // R10
    AST_VALID_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(start));                                            // R10
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(dst_out) && $stable(flags_out)));               // R10
    AST_ACTIVE_NZV_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (start && any_lane) |=> (flags_out[FLG_N] == 1'b0 && flags_out[FLG_Z] == 1'b0
                                 && flags_out[FLG_V] == 1'b0));             // R6
    AST_IDLE_FLAGS_KEPT: assert property (@(posedge clk) disable iff (rst)
        (start && !any_lane && !imm_carry) |=> (flags_out == $past(flags_in))); // R5
    AST_IMM_NZV_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (start && imm_carry && !skip_first) |=> (flags_out[FLG_N] == 1'b0
                                 && flags_out[FLG_Z] == 1'b0 && flags_out[FLG_V] == 1'b0)); // R8

    for (genvar k = 0; k < PRED_W; k++) begin : g_keep
        AST_BYTE_KEPT: assert property (@(posedge clk) disable iff (rst)
            (start && !pred[k]) |=> (dst_out[k*BYTE_W +: BYTE_W]
                                     == $past(dst_old[k*BYTE_W +: BYTE_W]))); // R4
    end
endmodule

bind vac_unit vac_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .imm_carry (imm_carry),
    .skip_first(skip_first),
    .dst_old   (dst_old),
    .pred      (pred),
    .flags_in  (flags_in),
    .dst_out   (dst_out),
    .flags_out (flags_out),
    .valid     (valid)
);

// File: tb/vac_unit_bench.sv
`timescale 1ns/1ps
module vac_unit_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         op_sub = 1'b0;
    logic         imm_carry = 1'b0;
    logic         skip_first = 1'b0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic [127:0] dst_old = '0;
    logic [15:0]  pred = '0;
    logic [3:0]   flags_in = '0;
    logic [127:0] dst_out;
    logic [3:0]   flags_out;
    logic         valid;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [127:0] exp_dst = '0;
    logic [3:0]   exp_flags = '0;
    logic         exp_valid = 1'b0;

    always #2 clk = ~clk;

    vac_unit u_vac_unit (
        .clk(clk), .rst(rst), .start(start), .op_sub(op_sub),
        .imm_carry(imm_carry), .skip_first(skip_first),
        .src_a(src_a), .src_b(src_b), .dst_old(dst_old), .pred(pred),
        .flags_in(flags_in), .dst_out(dst_out), .flags_out(flags_out),
        .valid(valid)
    );

    // Behavioural reference from the requirements
    task automatic model(output logic [127:0] d, output logic [3:0] f);
        logic [3:0]  base;
        logic        c;
        logic [32:0] r;
        logic [31:0] bv;
        bit          any;
        base = (imm_carry && !skip_first) ? {2'b00, op_sub, 1'b0} : flags_in;
        c    = base[1];
        any  = 0;
        d    = dst_old;
        for (int e = 0; e < 4; e++) begin
            bv = op_sub ? ~src_b[e*32 +: 32] : src_b[e*32 +: 32];
            r  = {1'b0, src_a[e*32 +: 32]} + {1'b0, bv} + {32'd0, c};
            if (pred[e*4]) begin
                c   = r[32];
                any = 1;
            end
            for (int j = 0; j < 4; j++)
                if (pred[e*4+j]) d[e*32+j*8 +: 8] = r[j*8 +: 8];
        end
        f = any ? {2'b00, c, 1'b0} : base;
    endtask

    task automatic check(input string tag);
        total++;
        if (valid !== exp_valid) begin
            bad++;
            $display("FAIL R10 valid act=%0b exp=%0b", valid, exp_valid);
        end
        total++;
        if (dst_out !== exp_dst) begin
            bad++;
            $display("FAIL %s dst act=%h exp=%h", tag, dst_out, exp_dst);
        end
        total++;
        if (flags_out !== exp_flags) begin
            bad++;
            $display("FAIL %s flags act=%b exp=%b", tag, flags_out, exp_flags);
        end
    endtask

    // Drive at a negedge, advance one cycle, compare at the next negedge
    task automatic step(input bit go, input string tag);
        logic [127:0] d;
        logic [3:0]   f;
        start = go;
        if (go) begin
            model(d, f);
            exp_dst   = d;
            exp_flags = f;
        end
        exp_valid = go;
        @(negedge clk);
        check(tag);
        start = 1'b0;
    endtask

    task automatic op(input bit sub, input bit imm, input bit skp,
                      input logic [127:0] a, input logic [127:0] b,
                      input logic [127:0] old, input logic [15:0] p,
                      input logic [3:0] fi, input string tag);
        op_sub = sub; imm_carry = imm; skip_first = skp;
        src_a = a; src_b = b; dst_old = old; pred = p; flags_in = fi;
        step(1, tag);
        // Scramble inputs while idle: outputs must hold
        src_a = ~a; pred = ~p; flags_in = ~fi;
        step(0, "R10");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10");   // reset state

        // R1: carry ripples through all lanes
        op(0, 0, 0, {32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
           128'h1, '1, 16'hFFFF, 4'b0000, "R1");
        // R1: final carry out of lane 3
        op(0, 0, 0, {4{32'hFFFF_FFFF}}, 128'h1, '0, 16'hFFFF, 4'b0000, "R1");
        // R2: subtract with fixed carry 1 -> a-b
        op(1, 1, 0, {4{32'd5}}, {4{32'd3}}, '0, 16'hFFFF, 4'b0000, "R2");
        // R2: subtract borrowing
        op(1, 1, 0, {4{32'd3}}, {4{32'd5}}, '0, 16'hFFFF, 4'b0000, "R2");
        // R3: lane 1 inactive, its overflow must not propagate
        op(0, 0, 0, {32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0},
           {32'h0, 32'h0, 32'h1, 32'h0}, {4{32'hDEAD_BEEF}}, 16'h0F0F, 4'b0000, "R3");
        // R3: inactive lane 0 passes incoming carry to lane 1
        op(0, 0, 0, {4{32'h7}}, {4{32'h1}}, '0, 16'hFFF0, 4'b0010, "R3");
        // R4: irregular byte predicate
        op(0, 0, 0, {4{32'h1122_3344}}, {4{32'h0101_0101}}, {16{8'hAA}},
           16'hA5C3, 4'b0000, "R4");
        // R5: lane bits clear, other bytes set; flags untouched
        op(0, 0, 0, {4{32'hFFFF_FFFF}}, {4{32'h1}}, {16{8'h55}}, 16'hEEEE, 4'b1101, "R5");
        // R5: no lanes with immediate carry gives fixed flags
        op(1, 1, 0, '1, '1, '0, 16'h0000, 4'b1111, "R5");
        // R6: N,Z,V forced low when active
        op(0, 0, 0, '0, '0, '0, 16'h0001, 4'b1111, "R6");
        // R7: carry in from flags
        op(0, 0, 0, '0, '0, '0, 16'hFFFF, 4'b0010, "R7");
        // R8: immediate add ignores incoming C
        op(0, 1, 0, '0, '0, '0, 16'hFFFF, 4'b1111, "R8");
        // R8: immediate subtract carries 1 regardless
        op(1, 1, 0, '0, '0, '1, 16'h000F, 4'b0000, "R8");
        // R9: skipped first beat uses incoming flags
        op(0, 1, 1, '0, '0, '0, 16'hFFFF, 4'b0010, "R9");
        op(1, 1, 1, {4{32'd5}}, {4{32'd3}}, '0, 16'hFFFF, 4'b0000, "R9");
        // back-to-back starts
        op_sub = 0; imm_carry = 0; skip_first = 0; pred = 16'hFFFF;
        src_a = '1; src_b = 128'h1; flags_in = 0; dst_old = 0;
        step(1, "R10");
        flags_in = 4'b0010;
        step(1, "R10");
        step(0, "R10");
        // random mix
        for (int n = 0; n < 60; n++) begin
            logic [127:0] ra, rb, ro;
            ra = {$urandom, $urandom, $urandom, $urandom};
            rb = {$urandom, $urandom, $urandom, $urandom};
            ro = {$urandom, $urandom, $urandom, $urandom};
            if (n % 3 == 0) rb = ~ra;
            op($urandom % 2, $urandom % 2, $urandom % 2, ra, rb, ro,
               16'($urandom), 4'($urandom), "R1");
        end
        // reset clears outputs
        rst = 1'b1;
        exp_dst = '0; exp_flags = '0; exp_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        check("R10");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R10 watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule